// File: doc/BRIEF.md
# Rotating-Pointer Victim Selection Tag Store

This block holds the tags of a fully associative store: 64 entries by default, where any tag may sit in any entry. Every entry carries a valid bit. A lookup presents a tag. In the same cycle, with no register on the path, the block reports whether a valid entry holds that tag and, if one does, which entry it is.

Victims are chosen with one replacement pointer rather than per-entry age history. The pointer always names exactly one entry, and that entry is the victim offered on a miss. The pointer steps forward only when the entry it names is accessed. An access is either a lookup that hits that entry or a fill written into it. A hit on any other entry leaves the pointer where it is. A fill is written into the entry under the pointer on the clock edge where it is presented.

Data storage, memory timing and write policy belong to the surrounding cache and are outside this block.

Top module: `ptr_lru_tags`

## Requirements
- R1: After synchronous reset, the pointer is 0 and every valid bit is clear, so no lookup hits, not even one for tag value 0.
- R2: When `lookup_valid` is high and a valid entry holds `lookup_tag`, `hit` is 1 and `hit_idx` gives that entry's index in the same cycle. When no valid entry holds the tag, `hit` is 0.
- R3: No two valid entries ever hold the same tag. A fill whose tag is already held by a valid entry is dropped: no entry changes and the pointer does not move.
- R4: `victim_idx` always equals the pointer. An accepted fill writes its tag into the entry under the pointer and sets that entry's valid bit, so a later lookup of that tag hits at that index.
- R5: A lookup that hits the entry under the pointer advances the pointer by one at the next clock edge.
- R6: A lookup that hits any other entry, with no accepted fill in the same cycle, leaves the pointer unchanged.
- R7: Advancing from the last entry (63 by default) moves the pointer to 0.
- R8: An accepted fill advances the pointer by exactly one. This still holds when a lookup in the same cycle hits the pointed entry.
- R9: A fill replaces the previous tag of the victim entry, so the old tag no longer hits.
- R10: A cycle with no hit and no accepted fill leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Lookup request present |
| lookup_tag | input | TAG_W | Tag to search for |
| hit | output | 1 | A valid entry holds lookup_tag (combinational) |
| hit_idx | output | IDX_W | Index of the matching entry; 0 when there is no hit |
| victim_idx | output | IDX_W | Entry that will be replaced on a miss |
| fill_valid | input | 1 | Install fill_tag at the victim entry on this edge |
| fill_tag | input | TAG_W | Tag to install |
| ptr | output | IDX_W | Current replacement pointer |

## Verification
The bench first fills every entry so the pointer wraps, then runs three directed checks. It hits the pointed entry and another entry: a design that always advances, or never advances, shows a wrong pointer at once. It presents a fill together with a lookup hit on the pointed entry: a design that adds the two advances skips an entry. It offers a fill of a tag the store already holds: a design without the duplicate guard installs a second copy and moves the pointer. A constrained random phase then mixes lookups, fills, duplicate fills and simultaneous operations against a reference model. The pointer is walked through the top entry to catch a wrap to a stray value.

// File: rtl/ptr_lru_pkg.sv
package ptr_lru_pkg;
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ptr_lru_tag_array.sv
module ptr_lru_tag_array #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned TAG_W   = 20,
  localparam int unsigned IDX_W  = ptr_lru_pkg::idx_width(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [TAG_W-1:0]   cmp_a_tag,
  input  logic [TAG_W-1:0]   cmp_b_tag,
  output logic [ENTRIES-1:0] match_a,
  output logic [ENTRIES-1:0] match_b,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_a[e] = valid_q[e] && (tag_q[e] == cmp_a_tag);
    assign match_b[e] = valid_q[e] && (tag_q[e] == cmp_b_tag);
  end

  assign valid_vec = valid_q;
endmodule

// File: rtl/ptr_lru_encoder.sv
module ptr_lru_encoder #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = ptr_lru_pkg::idx_width(ENTRIES)
) (
  input  logic [ENTRIES-1:0] onehot,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (onehot[e]) idx = idx | IDX_W'(e);
    end
  end
  assign any = |onehot;
endmodule

// File: rtl/ptr_lru_pointer.sv
module ptr_lru_pointer #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = ptr_lru_pkg::idx_width(ENTRIES),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (advance) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/ptr_lru_tags.sv
module ptr_lru_tags #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned TAG_W   = 20,
  localparam int unsigned IDX_W  = ptr_lru_pkg::idx_width(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lookup_valid,
  input  logic [TAG_W-1:0] lookup_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [IDX_W-1:0] victim_idx,
  input  logic             fill_valid,
  input  logic [TAG_W-1:0] fill_tag,
  output logic [IDX_W-1:0] ptr
);
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fl_match;
  logic [ENTRIES-1:0] valid_vec;
  logic               lk_any;
  logic               fl_dup;
  logic [IDX_W-1:0]   lk_idx;
  logic               fill_ok;
  logic               advance;
  logic [IDX_W-1:0]   ptr_w;

  ptr_lru_tag_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_array (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (fill_ok),
    .wr_idx    (ptr_w),
    .wr_tag    (fill_tag),
    .cmp_a_tag (lookup_tag),
    .cmp_b_tag (fill_tag),
    .match_a   (lk_match),
    .match_b   (fl_match),
    .valid_vec (valid_vec)
  );

  ptr_lru_encoder #(.ENTRIES(ENTRIES)) u_enc (
    .onehot (lk_match),
    .any    (lk_any),
    .idx    (lk_idx)
  );

  assign fl_dup  = |fl_match;
  assign hit     = lookup_valid && lk_any;
  assign hit_idx = hit ? lk_idx : '0;
  // duplicate tags are refused so every lookup matches at most one entry
  assign fill_ok = fill_valid && !fl_dup;
  assign advance = fill_ok || (hit && (lk_idx == ptr_w));

  ptr_lru_pointer #(.ENTRIES(ENTRIES)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .ptr     (ptr_w)
  );

  assign ptr        = ptr_w;
  assign victim_idx = ptr_w;
endmodule

// File: rtl/ptr_lru_tags_chk.sv
module ptr_lru_tags_chk #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = ptr_lru_pkg::idx_width(ENTRIES),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               lookup_valid,
  input logic               hit,
  input logic [IDX_W-1:0]   hit_idx,
  input logic               fill_ok,
  input logic [IDX_W-1:0]   ptr,
  input logic [ENTRIES-1:0] lk_match,
  input logic [ENTRIES-1:0] valid_vec
);
  // R3: at most one valid entry matches a looked-up tag
  a_r3_unique_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R5 and R7: a hit on the pointed entry steps the pointer, wrapping at the top
  a_r5_step_on_pointer_hit: assert property (@(posedge clk) disable iff (rst)
    (lookup_valid && hit && hit_idx == ptr) |=>
      ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

  // R8: an accepted fill steps the pointer by exactly one
  a_r8_step_on_fill: assert property (@(posedge clk) disable iff (rst)
    fill_ok |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

  // R6: a hit elsewhere leaves the pointer alone
  a_r6_hold_on_other_hit: assert property (@(posedge clk) disable iff (rst)
    (lookup_valid && hit && hit_idx != ptr && !fill_ok) |=> $stable(ptr));

  // R10: no access means no movement
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!hit && !fill_ok) |=> $stable(ptr));

  // R4: the filled entry is valid afterwards
  a_r4_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
    fill_ok |=> valid_vec[$past(ptr)]);
endmodule

bind ptr_lru_tags ptr_lru_tags_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lookup_valid (lookup_valid),
  .hit          (hit),
  .hit_idx      (hit_idx),
  .fill_ok      (fill_ok),
  .ptr          (ptr),
  .lk_match     (lk_match),
  .valid_vec    (valid_vec)
);

// File: tb/ptr_lru_tags_bench.sv
`timescale 1ns/1ps
module ptr_lru_tags_bench;
  localparam int N     = 64;
  localparam int TW    = 20;
  localparam int IW    = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lookup_valid = 1'b0;
  logic [TW-1:0] lookup_tag = '0;
  logic          hit;
  logic [IW-1:0] hit_idx;
  logic [IW-1:0] victim_idx;
  logic          fill_valid = 1'b0;
  logic [TW-1:0] fill_tag = '0;
  logic [IW-1:0] ptr;

  int n_run  = 0;
  int n_fail = 0;

  int mtag [N];
  bit mval [N];
  int mptr = 0;

  always #4 clk = ~clk;

  ptr_lru_tags #(.ENTRIES(N), .TAG_W(TW)) u_ptr_lru_tags (
    .clk(clk), .rst(rst), .lookup_valid(lookup_valid), .lookup_tag(lookup_tag),
    .hit(hit), .hit_idx(hit_idx), .victim_idx(victim_idx),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .ptr(ptr)
  );

  function automatic int find(input int t);
    for (int e = 0; e < N; e++) if (mval[e] && mtag[e] == t) return e;
    return -1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational outputs, then pointer after edge
  task automatic op(input bit lv, input int lt, input bit fv, input int ft, input string req);
    int  lk, fm;
    bit  eh, fok, adv;
    @(negedge clk);
    lookup_valid = lv; lookup_tag = TW'(lt);
    fill_valid   = fv; fill_tag   = TW'(ft);
    #1;
    lk  = lv ? find(lt) : -1;
    eh  = (lk >= 0);
    fm  = find(ft);
    fok = fv && (fm < 0);
    check({req, " R2 hit"}, int'(hit), int'(eh));
    if (eh) check({req, " R2 hit_idx"}, int'(hit_idx), lk);
    check({req, " R4 victim"}, int'(victim_idx), mptr);
    adv = fok || (eh && lk == mptr);
    if (fok) begin mtag[mptr] = ft; mval[mptr] = 1'b1; end
    if (adv) mptr = (mptr + 1) % N;
    @(posedge clk); #1;
    lookup_valid = 1'b0; fill_valid = 1'b0;
    check({req, " ptr"}, int'(ptr), mptr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int e = 0; e < N; e++) begin mtag[e] = 0; mval[e] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 reset ptr", int'(ptr), 0);
    op(1'b1, 0, 1'b0, 0, "R1 tag0 miss after reset");
    op(1'b1, 1000, 1'b0, 0, "R1 miss");
    // fill every entry; pointer wraps back to 0
    for (int e = 0; e < N; e++) op(1'b0, 0, 1'b1, 1000 + e, "R8 fill");
    check("R7 wrap after fills", int'(ptr), 0);
    op(1'b1, 1000, 1'b0, 0, "R5 hit at pointer");
    check("R5 advanced", int'(ptr), 1);
    op(1'b1, 1005, 1'b0, 0, "R6 hit elsewhere");
    check("R6 held", int'(ptr), 1);
    op(1'b0, 0, 1'b1, 2000, "R4 fill victim");
    check("R8 advanced", int'(ptr), 2);
    op(1'b1, 1001, 1'b0, 0, "R9 old tag gone");
    op(1'b1, 2000, 1'b0, 0, "R9 new tag at 1");
    op(1'b0, 0, 1'b1, 1010, "R3 duplicate fill dropped");
    check("R3 ptr held", int'(ptr), 2);
    op(1'b1, 1010, 1'b0, 0, "R3 still single copy");
    op(1'b0, 0, 1'b0, 0, "R10 idle");
    op(1'b1, 1002, 1'b1, 3000, "R8 fill with pointer hit");
    check("R8 single step", int'(ptr), 3);
    // walk the pointer through the top entry by hits
    for (int k = 0; k < N - 3; k++) op(1'b1, mtag[mptr], 1'b0, 0, "R7 walk");
    check("R7 wrap by hits", int'(ptr), 0);
    // constrained random mix
    for (int k = 0; k < 600; k++) begin
      int sel, ta, tb;
      sel = int'($urandom % 4);
      ta  = int'($urandom % 90) + 1;
      tb  = int'($urandom % 90) + 1;
      if (sel == 0) ta = mtag[mptr];
      case (sel)
        0, 1: op(1'b1, ta, 1'b0, 0, "R5 R6 random lookup");
        2:    op(1'b0, 0, 1'b1, tb, "R3 R8 random fill");
        default: op(1'b1, ta, 1'b1, tb, "R8 R9 random both");
      endcase
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule